// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block decides, cycle by cycle, whether a new task may enter a nonlinear pipeline whose stage usage pattern is fixed. The forbidden start distances are summarised in an M-bit collision vector: bit position `i-1` set to 1 means that a task starting `i` cycles after an earlier one would collide with it on some stage, and 0 means that distance is safe. Bit `M-1`, the largest forbidden distance, is always 1. Any distance larger than M is always safe.

The controller keeps the collision state captured at the most recent start, plus a counter of cycles elapsed since that start. The state bit selected by the counter tells whether the present cycle is a safe distance. When a task starts after distance `p`, the stored state becomes the old state shifted right by `p` positions, ORed with the active collision vector. Requests arrive on a valid/ready handshake. Because ready rises at the first safe cycle, a requester that holds valid high is admitted on the greedy schedule, always at the smallest safe distance. The vector comes from a parameter at reset and can be replaced at run time.

Top module: `cvc_init_ctrl`

## Requirements
- R1: After reset, `cv_state` equals `INIT_CV` with bit M-1 forced to 1, `since_cnt` equals M+1 and `req_ready` is 1.
- R2: While `since_cnt` is a value `p` in 1..M, `req_ready` is 0 exactly when any earlier start lies at a distance `d` (1 ≤ d ≤ M) from the present cycle with bit `d-1` of the active vector set. It is 0 in every cycle where `since_cnt` equals M.
- R3: Once more than M cycles have passed since the last start, `req_ready` is 1 (unless a load is present) and `cv_state` equals the active vector. An all-forbidden vector yields starts spaced exactly M+1 cycles apart.
- R4: On a start at distance `p`, `cv_state` in the next cycle is the previous `cv_state` shifted right by `p` (zero fill), ORed with the active vector. Without a start or load, it holds until the cycle in which `since_cnt` would pass M.
- R5: `task_start` is 1 exactly in cycles with `req_valid` and `req_ready` both 1. With `req_valid` held high, successive starts occur at the smallest safe distance.
- R6: `since_cnt` is 1 in the cycle after a start. It rises by one per cycle and saturates at M+1. In a start cycle it equals the distance used.
- R7: A cycle with `cv_load` high forces `req_ready` and `task_start` to 0. From the next cycle on, the active vector is `cv_value` with bit M-1 forced to 1, `cv_state` equals that vector, and `since_cnt` equals M+1.
- R8: Bit M-1 of `cv_state` is 1 in every cycle after reset, including after a load whose `cv_value` has that bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cv_load | input | 1 | Replace the active collision vector with `cv_value` |
| cv_value | input | MAX_LAT | New collision vector (bit i-1 = distance i forbidden) |
| req_valid | input | 1 | A task is waiting to start |
| req_ready | output | 1 | The present cycle is a safe start distance |
| task_start | output | 1 | A task starts this cycle |
| since_cnt | output | clog2(MAX_LAT+2) | Cycles since the last start, saturating at MAX_LAT+1 |
| cv_state | output | MAX_LAT | Collision state captured at the last start |

## Verification
A back-to-back burst from an idle pipeline exposes the greedy latency cycle. Any off-by-one in the shift distance or in the counter alignment changes the admitted sequence. Single requests separated by short gaps make starts land past the first safe distance, so the shift amount differs from the greedy one. A long idle stretch checks the return to the base vector and the saturation of the distance counter. Two reloaded vectors cover the extremes: only distance M forbidden gives back-to-back starts, and everything forbidden gives starts M+1 apart. A reload with its top bit cleared shows that bit being forced.

// File: rtl/cvc_pkg.sv
package cvc_pkg;
  // Kind of update applied to the collision state in a cycle.
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_LOAD  = 2'd1,
    UPD_START = 2'd2,
    UPD_IDLE  = 2'd3
  } upd_e;
endpackage

// File: rtl/cvc_shr.sv
// Logarithmic right shifter with zero fill; amounts at or beyond W clear the word.
module cvc_shr #(
  parameter int W  = 7,
  parameter int SW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:SW];

  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH >= W) begin : g_clear
      assign stg[k+1] = amt[k] ? '0 : stg[k];
    end else begin : g_shift
      assign stg[k+1] = amt[k] ? (stg[k] >> SH) : stg[k];
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/cvc_since_ctr.sv
// Distance counter: cycles since the last start, saturating at MAX_LAT+1.
module cvc_since_ctr #(
  parameter int MAX_LAT = 7,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          start,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] SAT = CW'(MAX_LAT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = SAT;
      cnt_en = 1'b1;
    end else if (start) begin
      cnt_d  = CW'(1);
      cnt_en = 1'b1;
    end else if (cnt_q != SAT) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= SAT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cvc_pick.sv
// Selects the state bit for the present distance; distance M+1 is never blocked.
module cvc_pick #(
  parameter int MAX_LAT = 7,
  parameter int CW      = 4
) (
  input  logic [MAX_LAT-1:0] state,
  input  logic [CW-1:0]      cnt,
  output logic               blocked
);
  logic [MAX_LAT-1:0] hit;

  for (genvar i = 0; i < MAX_LAT; i++) begin : g_hit
    assign hit[i] = state[i] & (cnt == CW'(i + 1));
  end

  assign blocked = |hit;
endmodule

// File: rtl/cvc_init_ctrl.sv
module cvc_init_ctrl
  import cvc_pkg::*;
#(
  parameter int                 MAX_LAT = 7,
  parameter logic [MAX_LAT-1:0] INIT_CV = 7'b1100101
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cv_load,
  input  logic [MAX_LAT-1:0]            cv_value,
  input  logic                          req_valid,
  output logic                          req_ready,
  output logic                          task_start,
  output logic [$clog2(MAX_LAT+2)-1:0]  since_cnt,
  output logic [MAX_LAT-1:0]            cv_state
);
  localparam int                 CW     = $clog2(MAX_LAT + 2);
  localparam logic [MAX_LAT-1:0] TOP    = {1'b1, {(MAX_LAT-1){1'b0}}};
  localparam logic [MAX_LAT-1:0] RST_CV = INIT_CV | TOP;

  logic [MAX_LAT-1:0] icv_q, icv_d;
  logic [MAX_LAT-1:0] st_q, st_d;
  logic               icv_en, st_en;
  logic [CW-1:0]      cnt;
  logic               blocked;
  logic               at_max;
  logic [MAX_LAT-1:0] st_shifted;
  upd_e               upd;

  cvc_since_ctr #(.MAX_LAT(MAX_LAT), .CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cv_load),
    .start (task_start),
    .cnt   (cnt)
  );

  cvc_pick #(.MAX_LAT(MAX_LAT), .CW(CW)) u_pick (
    .state   (st_q),
    .cnt     (cnt),
    .blocked (blocked)
  );

  cvc_shr #(.W(MAX_LAT), .SW(CW)) u_shr (
    .din  (st_q),
    .amt  (cnt),
    .dout (st_shifted)
  );

  assign req_ready  = !cv_load && !blocked;
  assign task_start = req_valid && req_ready;
  assign at_max     = (cnt == CW'(MAX_LAT));

  always_comb begin
    if (cv_load)         upd = UPD_LOAD;
    else if (task_start) upd = UPD_START;
    else if (at_max)     upd = UPD_IDLE;
    else                 upd = UPD_HOLD;
  end

  always_comb begin
    icv_d  = icv_q;
    st_d   = st_q;
    icv_en = 1'b0;
    st_en  = 1'b0;
    unique case (upd)
      UPD_LOAD: begin
        icv_d  = cv_value | TOP;
        st_d   = cv_value | TOP;
        icv_en = 1'b1;
        st_en  = 1'b1;
      end
      UPD_START: begin
        st_d  = st_shifted | icv_q;
        st_en = 1'b1;
      end
      UPD_IDLE: begin
        st_d  = icv_q;
        st_en = 1'b1;
      end
      default: begin
        st_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icv_q <= RST_CV;
    end else if (icv_en) begin
      icv_q <= icv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RST_CV;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign since_cnt = cnt;
  assign cv_state  = st_q;
endmodule

// File: rtl/cvc_init_ctrl_chk.sv
module cvc_init_ctrl_chk #(
  parameter int MAX_LAT = 7,
  parameter int CW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cv_load,
  input logic               req_valid,
  input logic               req_ready,
  input logic               task_start,
  input logic [CW-1:0]      since_cnt,
  input logic [MAX_LAT-1:0] cv_state
);
  localparam logic [CW-1:0] SAT = CW'(MAX_LAT + 1);

  assert_top_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cv_state[MAX_LAT-1]);

  assert_since_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    task_start |=> (since_cnt == CW'(1)));

  assert_since_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_cnt <= SAT) && (since_cnt != '0));

  assert_load_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cv_load |-> (!req_ready && !task_start));

  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cv_load |=> (since_cnt == SAT));

  assert_max_forbidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_cnt == CW'(MAX_LAT)) |-> !req_ready);

  assert_beyond_max_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_cnt == SAT) && !cv_load) |-> req_ready);

  assert_state_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!task_start && !cv_load && (since_cnt != CW'(MAX_LAT))) |=> $stable(cv_state));

  assert_start_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    task_start |-> req_valid);
endmodule

bind cvc_init_ctrl cvc_init_ctrl_chk #(.MAX_LAT(MAX_LAT), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cv_load    (cv_load),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .task_start (task_start),
  .since_cnt  (since_cnt),
  .cv_state   (cv_state)
);

// File: tb/test_cvc_init_ctrl.sv
module test_cvc_init_ctrl;
  localparam int             M    = 7;
  localparam int             CW   = $clog2(M + 2);
  localparam int             SAT  = M + 1;
  localparam logic [M-1:0]   ICV0 = 7'b1100101;
  localparam logic [M-1:0]   TOP  = 7'b1000000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cv_load;
  logic [M-1:0]  cv_value;
  logic          req_valid;
  logic          req_ready;
  logic          task_start;
  logic [CW-1:0] since_cnt;
  logic [M-1:0]  cv_state;

  always #10 clk = ~clk;

  cvc_init_ctrl #(.MAX_LAT(M), .INIT_CV(ICV0)) i_cvc_init_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cv_load    (cv_load),
    .cv_value   (cv_value),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .task_start (task_start),
    .since_cnt  (since_cnt),
    .cv_state   (cv_state)
  );

  int           cyc = 0;
  int           checks = 0;
  int           fails = 0;
  int           fires = 0;
  int           hist[$];
  int           exp_lat[$];
  logic [M-1:0] m_icv = ICV0 | TOP;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Collision if any earlier start sits at a forbidden distance from cycle t.
  function automatic bit collide(input int t, input int h[$], input logic [M-1:0] icv);
    foreach (h[k]) begin
      int d = t - h[k];
      if (d >= 1 && d <= M && icv[d-1]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int lat_of(input int t, input int h[$]);
    int d;
    if (h.size() == 0) return SAT;
    d = t - h[h.size()-1];
    return (d > SAT) ? SAT : d;
  endfunction

  // State captured at the last start: bit j = distance j+1 after it is forbidden.
  function automatic logic [M-1:0] state_of(input int t, input int h[$],
                                            input logic [M-1:0] icv);
    logic [M-1:0] s;
    int last;
    if (h.size() == 0) return icv;
    last = h[h.size()-1];
    if (t - last > M) return icv;
    s = '0;
    for (int j = 0; j < M; j++) begin
      foreach (h[k]) begin
        int d = last - h[k] + j + 1;
        if (d <= M && icv[d-1]) s[j] = 1'b1;
      end
    end
    return s;
  endfunction

  // Monitor: per-cycle model comparison and scoreboard pop on each start.
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_rdy;
      exp_rdy = !cv_load && !collide(cyc, hist, m_icv);
      check(req_ready == exp_rdy, "R2", "req_ready", int'(req_ready), int'(exp_rdy));
      check(int'(since_cnt) == lat_of(cyc, hist), "R6", "since_cnt",
            int'(since_cnt), lat_of(cyc, hist));
      check(cv_state == state_of(cyc, hist, m_icv), "R4", "cv_state",
            int'(cv_state), int'(state_of(cyc, hist, m_icv)));
      if (cv_load) begin
        check(task_start == 1'b0, "R7", "task_start in load cycle", int'(task_start), 0);
        m_icv = cv_value | TOP;
        hist.delete();
      end else if (req_valid && exp_rdy) begin
        check(task_start == 1'b1, "R5", "task_start", int'(task_start), 1);
        if (exp_lat.size() > 0) begin
          int e;
          e = exp_lat.pop_front();
          check(int'(since_cnt) == e, "R5", "greedy latency", int'(since_cnt), e);
        end else begin
          check(1'b0, "R5", "unexpected start", 1, 0);
        end
        hist.push_back(cyc);
        fires++;
      end else begin
        check(task_start == 1'b0, "R5", "task_start idle", int'(task_start), 0);
      end
    end
  end

  // Driver: holds valid for n starts, pushing the greedy latencies it expects.
  task automatic burst(input int n);
    int h[$];
    int t;
    int target;
    @(posedge clk); #2;
    h = hist;
    t = cyc;
    for (int i = 0; i < n; i++) begin
      while (collide(t, h, m_icv)) t++;
      exp_lat.push_back(lat_of(t, h));
      h.push_back(t);
      t++;
    end
    target = fires + n;
    req_valid = 1'b1;
    forever begin
      @(posedge clk); #2;
      if (fires >= target) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic load_cv(input logic [M-1:0] v, input bit with_req);
    @(posedge clk); #2;
    cv_load   = 1'b1;
    cv_value  = v;
    req_valid = with_req;
    @(posedge clk); #2;
    cv_load   = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic run_all();
    cv_load = 1'b0; cv_value = '0; req_valid = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    check(cv_state == (ICV0 | TOP), "R1", "reset cv_state", int'(cv_state), int'(ICV0 | TOP));
    check(int'(since_cnt) == SAT, "R1", "reset since_cnt", int'(since_cnt), SAT);
    check(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);

    burst(6);
    idle(3);
    burst(1);
    idle(1);
    burst(3);
    idle(12);
    @(negedge clk); #1;
    check(int'(since_cnt) == SAT, "R3", "since_cnt after idle", int'(since_cnt), SAT);
    check(cv_state == m_icv, "R3", "state back to vector", int'(cv_state), int'(m_icv));
    check(req_ready == 1'b1, "R3", "ready after idle", int'(req_ready), 1);
    burst(4);

    load_cv(7'b0001010, 1'b1);
    @(negedge clk); #1;
    check(cv_state == 7'b1001010, "R8", "top bit forced on load", int'(cv_state), 7'b1001010);
    check(int'(since_cnt) == SAT, "R7", "since_cnt after load", int'(since_cnt), SAT);
    burst(8);

    load_cv(7'b1000000, 1'b0);
    burst(10);
    load_cv(7'b0111111, 1'b0);
    burst(3);
    idle(2);
    check(exp_lat.size() == 0, "R5", "scoreboard drained", exp_lat.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule